// File: doc/BRIEF.md
# Recirculating Line Store Timing Controller

This block models the main store of a serial machine whose memory is a set of recirculating lines. Each line holds 32 words. The words pass a read point one after another, one word per minor cycle, and a minor cycle lasts a fixed number of digit periods (one digit period per clock). A free-running timebase counts digit periods and minor cycles. The minor-cycle count names the word position that is passing the read point at that moment.

A transfer request names a line, a wait number (the minor cycle in which the transfer starts), a characteristic (how many consecutive words to move) and a timing number (the minor cycle in which the next instruction would be fetched). The controller does not give random access. It idles until the named position comes round, moves one word per minor cycle, and then waits again until the timing position comes round. At that point it raises a next-fetch pulse and becomes free. Access latency therefore depends on where the wanted word is in its circulation. Word-parallel arrays stand in for the serial lines, and the timing of those lines is kept exactly.

Top module: `delayLineStore`

## Requirements
- R1: Both counters reset to 0. The digit counter steps by one each clock and wraps from DIGITS-1 to 0. The 5-bit minor-cycle counter steps by one on that wrap, modulo 32.
- R2: A request on `reqValid` is taken only while `busy` is low, and `busy` is high in the following clock. A request presented while `busy` is high is dropped. It is not queued, it moves no word and it changes no stored word.
- R3: A minor cycle "starts" at a clock edge where the digit counter reads 0. The first word moves at the start of minor cycle W (the wait number). Let c be the first minor cycle that starts after the accepting edge. The stall is (W − c) mod 32 whole minor cycles, so W = c moves at once and W = c − 1 waits 31 minor cycles. `wordStrobe` is high for one clock after each moved word, when `minorCnt` equals that word's position and `digitCnt` is 1.
- R4: The characteristic gives the word count, and a value of 0 moves one word. Words move in consecutive minor cycles at positions W, W+1, … and wrap from 31 to 0.
- R5: On a read, `rdData` holds the stored word of the addressed position while `wordStrobe` is high.
- R6: On a write, `wrData` is sampled at each word's slot edge. The value for word i+1 must be presented after the `wordStrobe` of word i.
- R7: Line numbers 1 to NUM_LINES (at most 7) select a line. Line number 0, or any number above NUM_LINES, selects nothing: reads return zero and writes are discarded.
- R8: After the last word, `nextFetch` pulses for one clock at the start of the first later minor cycle equal to the timing number. It is seen with `minorCnt` equal to that number and `digitCnt` 1, and `busy` falls in the same clock.
- R9: `rdData` keeps its value in every clock without a word transfer.
- R10: Lines are independent. A write to one line leaves every other line's word at the same position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digit-period clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Transfer request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLine | input | 3 | Line number, 1..NUM_LINES valid |
| reqWait | input | 5 | Minor cycle of the first word |
| reqChar | input | 5 | Word count (0 treated as 1) |
| reqTiming | input | 5 | Minor cycle of the next fetch |
| wrData | input | WORD_W | Write word for the current slot |
| busy | output | 1 | Request in progress |
| wordStrobe | output | 1 | One word moved in the previous slot |
| rdData | output | WORD_W | Word read in the last transfer |
| nextFetch | output | 1 | Timing position reached, controller free |
| digitCnt | output | $clog2(DIGITS) | Digit position within the minor cycle |
| minorCnt | output | 5 | Word position at the read point |

## Verification
On every cycle, the assertions check the stepping of both counters. They also check that word strobes and next-fetch pulses fall on digit 1 of a minor cycle, that strobes occur only while busy, that busy follows acceptance and that the read register holds between transfers. Other behaviours depend on the fields of the request and on the stored contents, so only the bench scenarios can show them. These are the exact stall length for a given starting position (including the immediate case and the worst case), the address wrap, the one-word minimum, data integrity per line, the null line number, and the dropping of a request made while busy.

// File: rtl/delayLineStorePkg.sv
package delayLineStorePkg;
  localparam int MINOR_W = 5;
  localparam int LINE_WORDS = 1 << MINOR_W;
  localparam int LINE_SEL_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_SEEK, ST_NEXT} ctlStateT;

  typedef struct packed {
    logic xfer;
    logic write;
    logic [LINE_SEL_W-1:0] line;
    logic [MINOR_W-1:0] addr;
  } ctlStrobeT;
endpackage

// File: rtl/delayLineTimebase.sv
module delayLineTimebase
  import delayLineStorePkg::*;
#(
  parameter int DIGITS = 32,
  localparam int DIG_W = $clog2(DIGITS)
) (
  input  logic               clk,
  input  logic               rstN,
  output logic [DIG_W-1:0]   digitCnt,
  output logic [MINOR_W-1:0] minorCnt,
  output logic               slotStart
);
  localparam logic [DIG_W-1:0] LAST_DIGIT = DIG_W'(DIGITS - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      digitCnt <= '0;
      minorCnt <= '0;
    end else if (digitCnt == LAST_DIGIT) begin
      digitCnt <= '0;
      minorCnt <= minorCnt + 1'b1;
    end else begin
      digitCnt <= digitCnt + 1'b1;
    end
  end

  assign slotStart = (digitCnt == '0);
endmodule

// File: rtl/delayLineControl.sv
module delayLineControl
  import delayLineStorePkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  slotStart,
  input  logic [MINOR_W-1:0]    minorCnt,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [LINE_SEL_W-1:0] reqLine,
  input  logic [MINOR_W-1:0]    reqWait,
  input  logic [MINOR_W-1:0]    reqChar,
  input  logic [MINOR_W-1:0]    reqTiming,
  output ctlStrobeT             ctl,
  output logic                  busy,
  output logic                  wordStrobe,
  output logic                  nextFetch
);
  ctlStateT state;
  logic [LINE_SEL_W-1:0] lineR;
  logic [MINOR_W-1:0] addrR;
  logic [MINOR_W-1:0] remR;
  logic [MINOR_W-1:0] timingR;
  logic writeR;
  logic slotHit;
  logic timingHit;

  assign slotHit   = slotStart && (state == ST_SEEK) && (minorCnt == addrR);
  assign timingHit = slotStart && (state == ST_NEXT) && (minorCnt == timingR);

  always_comb begin
    ctl.xfer  = slotHit;
    ctl.write = writeR;
    ctl.line  = lineR;
    ctl.addr  = addrR;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      lineR      <= '0;
      addrR      <= '0;
      remR       <= '0;
      timingR    <= '0;
      writeR     <= 1'b0;
      wordStrobe <= 1'b0;
      nextFetch  <= 1'b0;
    end else begin
      wordStrobe <= 1'b0;
      nextFetch  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            lineR   <= reqLine;
            addrR   <= reqWait;
            writeR  <= reqWrite;
            remR    <= (reqChar == '0) ? MINOR_W'(1) : reqChar;
            timingR <= reqTiming;
            state   <= ST_SEEK;
          end
        end
        ST_SEEK: begin
          if (slotHit) begin
            wordStrobe <= 1'b1;
            addrR      <= addrR + 1'b1;
            remR       <= remR - 1'b1;
            if (remR == MINOR_W'(1)) state <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (timingHit) begin
            nextFetch <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/delayLineArray.sv
module delayLineArray
  import delayLineStorePkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NUM_LINES = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] rowWord [NUM_LINES];
  logic [WORD_W-1:0] selWord;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    localparam logic [LINE_SEL_W-1:0] LINE_ID = LINE_SEL_W'(g + 1);
    logic [WORD_W-1:0] lineMem [LINE_WORDS];

    always_ff @(posedge clk) begin
      if (ctl.xfer && ctl.write && (ctl.line == LINE_ID))
        lineMem[ctl.addr] <= wrData;
    end

    assign rowWord[g] = lineMem[ctl.addr];
  end

  always_comb begin
    selWord = '0;
    for (int k = 0; k < NUM_LINES; k++)
      if (ctl.line == LINE_SEL_W'(k + 1)) selWord = rowWord[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (ctl.xfer) rdData <= selWord;
  end
endmodule

// File: rtl/delayLineStore.sv
module delayLineStore
  import delayLineStorePkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIGITS = 32,
  parameter int NUM_LINES = 7,
  localparam int DIG_W = $clog2(DIGITS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [LINE_SEL_W-1:0] reqLine,
  input  logic [MINOR_W-1:0]    reqWait,
  input  logic [MINOR_W-1:0]    reqChar,
  input  logic [MINOR_W-1:0]    reqTiming,
  input  logic [WORD_W-1:0]     wrData,
  output logic                  busy,
  output logic                  wordStrobe,
  output logic [WORD_W-1:0]     rdData,
  output logic                  nextFetch,
  output logic [DIG_W-1:0]      digitCnt,
  output logic [MINOR_W-1:0]    minorCnt
);
  logic slotStart;
  ctlStrobeT ctl;

  delayLineTimebase #(.DIGITS(DIGITS)) u_timebase (
    .clk(clk), .rstN(rstN), .digitCnt(digitCnt), .minorCnt(minorCnt),
    .slotStart(slotStart)
  );

  delayLineControl u_control (
    .clk(clk), .rstN(rstN), .slotStart(slotStart), .minorCnt(minorCnt),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqLine(reqLine),
    .reqWait(reqWait), .reqChar(reqChar), .reqTiming(reqTiming),
    .ctl(ctl), .busy(busy), .wordStrobe(wordStrobe), .nextFetch(nextFetch)
  );

  delayLineArray #(.WORD_W(WORD_W), .NUM_LINES(NUM_LINES)) u_array (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/delayLineStore_chk.sv
module delayLineStore_chk #(
  parameter int WORD_W = 32,
  parameter int DIGITS = 32,
  localparam int DIG_W = $clog2(DIGITS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [2:0]        reqLine,
  input logic [4:0]        reqWait,
  input logic [4:0]        reqChar,
  input logic [4:0]        reqTiming,
  input logic [WORD_W-1:0] wrData,
  input logic              busy,
  input logic              wordStrobe,
  input logic [WORD_W-1:0] rdData,
  input logic              nextFetch,
  input logic [DIG_W-1:0]  digitCnt,
  input logic [4:0]        minorCnt
);
  localparam logic [DIG_W-1:0] LAST_DIGIT = DIG_W'(DIGITS - 1);

  // R1
  digit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (($past(digitCnt) == LAST_DIGIT) ? (digitCnt == '0)
                                                      : (digitCnt == $past(digitCnt) + 1'b1)));

  // R1
  minor_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (($past(digitCnt) == LAST_DIGIT) ? (minorCnt == $past(minorCnt) + 5'd1)
                                                      : (minorCnt == $past(minorCnt))));

  // R3
  strobe_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordStrobe |-> (digitCnt == DIG_W'(1)));

  // R2
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordStrobe |-> busy);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(busy) && $past(reqValid)) |-> busy);

  // R8
  next_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    nextFetch |-> (!busy && $past(busy) && digitCnt == DIG_W'(1)));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !wordStrobe) |-> $stable(rdData));
endmodule

bind delayLineStore delayLineStore_chk #(.WORD_W(WORD_W), .DIGITS(DIGITS)) u_chk (.*);

// File: tb/delayLineStore_tb.sv
module delayLineStore_tb;
  localparam int DIGITS = 32;
  localparam int WORD_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [2:0] reqLine = '0;
  logic [4:0] reqWait = '0;
  logic [4:0] reqChar = '0;
  logic [4:0] reqTiming = '0;
  logic [WORD_W-1:0] wrData = '0;
  logic busy, wordStrobe, nextFetch;
  logic [WORD_W-1:0] rdData;
  logic [4:0] digitCnt;
  logic [4:0] minorCnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] model [1:7][0:31];

  always #4 clk = ~clk;

  delayLineStore #(.WORD_W(WORD_W), .DIGITS(DIGITS), .NUM_LINES(7)) u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doXfer(input bit wr, input int line, input bit rel, input int waitArg,
                        input int chr, input int timing, input logic [31:0] base,
                        input bit poke, input string tag);
    int d, m, w, len, cnt, exp, lastCnt, lastA, expN, a;
    bit lineOk;
    logic [31:0] expData;
    @(negedge clk);
    check(!busy, "R2", {tag, " idle before request"}, busy, 0);
    d = digitCnt; m = minorCnt;
    w = rel ? (m + 1 + waitArg) % 32 : waitArg;
    len = (chr == 0) ? 1 : chr;
    lineOk = (line >= 1 && line <= 7);
    reqValid = 1; reqWrite = wr; reqLine = 3'(line); reqWait = 5'(w);
    reqChar = 5'(chr); reqTiming = 5'(timing); wrData = base;
    exp = DIGITS + 1 - d + ((w - m - 1 + 64) % 32) * DIGITS;
    @(negedge clk); cnt = 1; reqValid = 0;
    check(busy, "R2", {tag, " busy after accept"}, busy, 1);
    if (poke) begin
      reqValid = 1; reqWrite = 1; reqLine = 3'd1; reqWait = 5'd5; reqChar = 5'd1;
      @(negedge clk); cnt++; reqValid = 0;
    end
    lastCnt = 0; lastA = w;
    for (int i = 0; i < len; i++) begin
      while (!wordStrobe && cnt < exp + 2) begin @(negedge clk); cnt++; end
      check(wordStrobe && cnt == exp, "R3", {tag, " word slot clock"}, cnt, exp);
      a = (w + i) % 32;
      check(minorCnt == 5'(a), "R4", {tag, " word position"}, minorCnt, a);
      if (wr) begin
        if (lineOk) model[line][a] = base + 32'(i);
        wrData = base + 32'(i + 1);
      end else begin
        expData = lineOk ? model[line][a] : 32'h0;
        check(rdData == expData, lineOk ? "R5" : "R7", {tag, " read word"}, rdData, expData);
      end
      lastCnt = cnt; lastA = a; exp += DIGITS;
      @(negedge clk); cnt++;
      if (!wr) check(rdData == expData, "R9", {tag, " read hold"}, rdData, expData);
    end
    expN = lastCnt + (((timing - lastA - 1 + 64) % 32) + 1) * DIGITS;
    while (!nextFetch && cnt < expN + 2) begin @(negedge clk); cnt++; end
    check(nextFetch && cnt == expN, "R8", {tag, " next fetch clock"}, cnt, expN);
    check(minorCnt == 5'(timing) && !busy, "R8", {tag, " next fetch position"},
          minorCnt, timing);
  endtask

  task automatic resetTask();
    @(negedge clk);
    check(digitCnt == 0 && minorCnt == 0, "R1", "counters in reset", {digitCnt, minorCnt}, 0);
    check(!busy && !wordStrobe && !nextFetch, "R2", "outputs idle in reset",
          {busy, wordStrobe, nextFetch}, 0);
    rstN = 1;
  endtask

  task automatic timebaseTask();
    repeat (DIGITS * 33 + 5) @(negedge clk);
    check(digitCnt == 5 && minorCnt == 1, "R1", "counter positions after run",
          {digitCnt, minorCnt}, {5'd5, 5'd1});
  endtask

  task automatic fillTask();
    doXfer(1, 1, 0, 0, 31, 3, 32'h1000_0000, 0, "fill");
    doXfer(1, 1, 0, 30, 4, 10, 32'h2222_0000, 0, "R4 wrap write");
    doXfer(0, 1, 0, 30, 4, 2, 0, 0, "R6 wrap readback");
  endtask

  task automatic latencyTask();
    doXfer(0, 1, 1, 0, 2, 20, 0, 0, "R3 immediate");
    doXfer(0, 1, 1, 31, 1, 0, 0, 0, "R3 worst case");
    doXfer(1, 1, 1, 0, 0, 9, 32'h5A5A_0000, 0, "R4 zero char write");
    doXfer(0, 1, 1, 7, 0, 9, 0, 0, "R4 zero char read");
  endtask

  task automatic lineTask();
    doXfer(1, 0, 0, 7, 1, 12, 32'hBAD0_0000, 0, "R7 null write");
    doXfer(0, 1, 0, 7, 1, 12, 0, 0, "R7 line1 untouched");
    doXfer(0, 0, 0, 7, 1, 12, 0, 0, "R7 null read");
    doXfer(1, 7, 0, 3, 2, 31, 32'h7777_0000, 0, "R10 top line write");
    doXfer(1, 2, 0, 3, 3, 8, 32'h3333_0000, 0, "R10 line2 write");
    doXfer(0, 1, 0, 3, 3, 8, 0, 0, "R10 line1 unchanged");
    doXfer(0, 7, 0, 3, 2, 8, 0, 0, "R10 top line readback");
    doXfer(0, 2, 0, 3, 3, 8, 0, 0, "R10 line2 readback");
  endtask

  task automatic ignoreTask();
    bit sawStrobe;
    doXfer(0, 1, 1, 20, 2, 4, 0, 1, "R2 busy poke");
    sawStrobe = 0;
    for (int k = 0; k < 40 * DIGITS; k++) begin
      @(negedge clk);
      if (wordStrobe || busy) sawStrobe = 1;
    end
    check(!sawStrobe, "R2", "dropped request stays silent", sawStrobe, 0);
    doXfer(0, 1, 0, 5, 1, 6, 0, 0, "R2 word unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    resetTask();
    timebaseTask();
    fillTask();
    latencyTask();
    lineTask();
    ignoreTask();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule